// File: doc/BRIEF.md
# Exclusive Two-Level Cache Request Router

This block sits between a processor's request port and the coherence controller of a cache hierarchy with separate instruction and data first-level arrays and a shared second-level array whose contents never overlap. For each pending request it looks at tag-presence and free-way indications from the three arrays. It then picks exactly one action for the current cycle, together with the address that action applies to.

When the line is already in the correct first-level array, or when nothing stands in the way of a fetch, the request goes to the coherence controller as a load, fetch or store. In every other case the block emits one preparatory step instead. That step moves a line between levels or evicts a second-level victim. The request stays pending and is judged again once the step has been accepted and the array indications have been updated. Array contents and data movement live outside the block, and the arrays appear only as flags and victim addresses.

Actions leave through a registered valid/ready output. The register loads only when it is empty and holds its contents until accepted. A request is consumed only in the cycle its issue action is accepted.

Top module: `cache_req_router`

## Requirements
- R1: After reset, act_valid, req_ready, excl_err and kind_err are low.
- R2: When a fetch finds its line in the data L1, or a load/store/atomic finds it in the instruction L1, and l2_free_req is high, the action is the L1-to-L2 move for that wrong-side array (bit 2 for the data L1, bit 1 for the instruction L1), with act_addr = req_addr.
- R3: In the wrong-side case of R2 with l2_free_req low, the action is an L2 eviction (bit 5), with act_addr = l2_vic_req_addr.
- R4: A hit in the correct L1 gives an issue action (bit 0) with act_addr = req_addr. issue_op is 0 for load (kind 0), 1 for fetch (kind 1), and 2 for store (kind 2) or atomic (kind 3).
- R5: When neither L1 holds the line, the correct L1 has a free way and hit_l2 is high, the action is the L2-to-L1 move into that array (bit 3 instruction, bit 4 data), with act_addr = req_addr.
- R6: When neither L1 holds the line, the correct L1 has a free way and the L2 does not hold it, the action is an issue (bit 0), with act_addr = req_addr.
- R7: When neither L1 holds the line, the correct L1 has no free way and l2_free_vic is high, the action moves that L1's victim to L2 (bit 1 or 2). act_addr is the victim address of that L1.
- R8: In the case of R7 with l2_free_vic low, the action is an L2 eviction (bit 5), with act_addr = l2_vic_vic_addr.
- R9: excl_err is high whenever req_valid is high and more than one of hit_l1i, hit_l1d, hit_l2 is high. It is low for any pattern with at most one of them high.
- R10: A request with kind 4 to 7 raises kind_err and is consumed at once (req_ready high while the output is empty). No action is latched for it.
- R11: A legal request seen while the output is empty gives act_valid one cycle later, with exactly one act_onehot bit set. act_onehot, act_addr and issue_op hold while act_ready is low. act_valid falls in the cycle after acceptance.
- R12: req_ready rises only in a cycle where an issue action is accepted. Accepting a move or eviction leaves req_ready low, and the request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request pending |
| req_ready | output | 1 | Request consumed this cycle |
| req_kind | input | 3 | 0 load, 1 fetch, 2 store, 3 atomic, others illegal |
| req_addr | input | AW | Request line address |
| hit_l1i | input | 1 | Instruction L1 holds the request line |
| hit_l1d | input | 1 | Data L1 holds the request line |
| hit_l2 | input | 1 | L2 holds the request line |
| free_l1i | input | 1 | Instruction L1 set of the request has a free way |
| free_l1d | input | 1 | Data L1 set of the request has a free way |
| l2_free_req | input | 1 | L2 set of the request address has a free way |
| l2_free_vic | input | 1 | L2 set of the correct L1's victim has a free way |
| l1i_vic_addr | input | AW | Victim address chosen by the instruction L1 |
| l1d_vic_addr | input | AW | Victim address chosen by the data L1 |
| l2_vic_req_addr | input | AW | L2 victim for the request address |
| l2_vic_vic_addr | input | AW | L2 victim for the L1 victim's address |
| act_valid | output | 1 | Action register holds an action |
| act_ready | input | 1 | Downstream accepts the action |
| act_onehot | output | 6 | 0 issue, 1 L1I to L2, 2 L1D to L2, 3 L2 to L1I, 4 L2 to L1D, 5 evict L2 |
| act_addr | output | AW | Address the action applies to |
| issue_op | output | 2 | Coherence op for an issue: 0 load, 1 fetch, 2 store |
| excl_err | output | 1 | More than one array reports a hit |
| kind_err | output | 1 | Illegal request kind |

## Verification
The main decision is swept over every legal kind, every exclusive hit pattern (none, instruction L1, data L1, L2) and all sixteen combinations of the four free-way flags. Every request address and victim address in this sweep differs from the others. A wrong act_addr therefore shows which of the five sources was picked by mistake, and a wrong bit shows which branch of the priority order was taken. Each case is also held with act_ready low and then accepted. This separates stability, consumption on issue and pendency after a preparatory step. The multi-hit patterns and the four illegal kinds are applied on their own to check the two error flags, and to confirm that no action is produced.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
  localparam int ACT_N   = 6;
  localparam int A_ISSUE = 0;
  localparam int A_I2L2  = 1;
  localparam int A_D2L2  = 2;
  localparam int A_L2I   = 3;
  localparam int A_L2D   = 4;
  localparam int A_EVICT = 5;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_FETCH = 2'd1,
    OP_STORE = 2'd2
  } op_e;

  function automatic logic [ACT_N-1:0] act_bit(input int idx);
    logic [ACT_N-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  function automatic logic kind_legal(input logic [2:0] k);
    return k[2] == 1'b0;
  endfunction
endpackage

// File: rtl/rtr_classify.sv
module rtr_classify
  import rtr_pkg::*;
(
  input  logic [2:0] kind,
  output logic       is_fetch,
  output op_e        op,
  output logic       bad
);
  always_comb begin
    bad      = !kind_legal(kind);
    is_fetch = (kind == 3'd1);
    unique case (kind[1:0])
      2'd0:    op = OP_LOAD;
      2'd1:    op = OP_FETCH;
      default: op = OP_STORE;
    endcase
  end
endmodule

// File: rtl/rtr_select.sv
module rtr_select
  import rtr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             is_fetch,
  input  logic             hit_i,
  input  logic             hit_d,
  input  logic             hit_l2,
  input  logic             free_i,
  input  logic             free_d,
  input  logic             l2_free_req,
  input  logic             l2_free_vic,
  input  logic [AW-1:0]    req_addr,
  input  logic [AW-1:0]    vic_i,
  input  logic [AW-1:0]    vic_d,
  input  logic [AW-1:0]    l2v_req,
  input  logic [AW-1:0]    l2v_vic,
  output logic [ACT_N-1:0] act,
  output logic [AW-1:0]    tgt
);
  logic wrong_hit, right_hit, right_free;
  logic [AW-1:0] right_vic;

  always_comb begin
    wrong_hit  = is_fetch ? hit_d  : hit_i;
    right_hit  = is_fetch ? hit_i  : hit_d;
    right_free = is_fetch ? free_i : free_d;
    right_vic  = is_fetch ? vic_i  : vic_d;
  end

  always_comb begin
    act = act_bit(A_ISSUE);
    tgt = req_addr;
    if (wrong_hit) begin
      if (l2_free_req) begin
        act = is_fetch ? act_bit(A_D2L2) : act_bit(A_I2L2);
      end else begin
        act = act_bit(A_EVICT);
        tgt = l2v_req;
      end
    end else if (right_hit) begin
      act = act_bit(A_ISSUE);
    end else if (right_free) begin
      if (hit_l2) act = is_fetch ? act_bit(A_L2I) : act_bit(A_L2D);
    end else if (l2_free_vic) begin
      act = is_fetch ? act_bit(A_I2L2) : act_bit(A_D2L2);
      tgt = right_vic;
    end else begin
      act = act_bit(A_EVICT);
      tgt = l2v_vic;
    end
  end
endmodule

// File: rtl/rtr_hold.sv
module rtr_hold
  import rtr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ACT_N-1:0] act_in,
  input  logic [AW-1:0]    addr_in,
  input  op_e              op_in,
  input  logic             ready,
  output logic             valid,
  output logic [ACT_N-1:0] act_q,
  output logic [AW-1:0]    addr_q,
  output op_e              op_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      act_q  <= '0;
      addr_q <= '0;
      op_q   <= OP_LOAD;
    end else if (!valid) begin
      if (load) begin
        valid  <= 1'b1;
        act_q  <= act_in;
        addr_q <= addr_in;
        op_q   <= op_in;
      end
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  assert_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $countones(act_q) == 1);
  assert_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(act_q) && $stable(addr_q) && $stable(op_q));
  assert_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    valid && ready |=> !valid);
endmodule

// File: rtl/cache_req_router.sv
module cache_req_router
  import rtr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_kind,
  input  logic [AW-1:0]    req_addr,
  input  logic             hit_l1i,
  input  logic             hit_l1d,
  input  logic             hit_l2,
  input  logic             free_l1i,
  input  logic             free_l1d,
  input  logic             l2_free_req,
  input  logic             l2_free_vic,
  input  logic [AW-1:0]    l1i_vic_addr,
  input  logic [AW-1:0]    l1d_vic_addr,
  input  logic [AW-1:0]    l2_vic_req_addr,
  input  logic [AW-1:0]    l2_vic_vic_addr,
  output logic             act_valid,
  input  logic             act_ready,
  output logic [ACT_N-1:0] act_onehot,
  output logic [AW-1:0]    act_addr,
  output logic [1:0]       issue_op,
  output logic             excl_err,
  output logic             kind_err
);
  logic             is_fetch, bad_kind, load_new, issue_taken;
  op_e              op_c, op_q;
  logic [ACT_N-1:0] act_c;
  logic [AW-1:0]    tgt_c;

  rtr_classify u_cls (.kind(req_kind), .is_fetch(is_fetch), .op(op_c), .bad(bad_kind));

  rtr_select #(.AW(AW)) u_sel (
    .is_fetch(is_fetch), .hit_i(hit_l1i), .hit_d(hit_l1d), .hit_l2(hit_l2),
    .free_i(free_l1i), .free_d(free_l1d), .l2_free_req(l2_free_req),
    .l2_free_vic(l2_free_vic), .req_addr(req_addr), .vic_i(l1i_vic_addr),
    .vic_d(l1d_vic_addr), .l2v_req(l2_vic_req_addr), .l2v_vic(l2_vic_vic_addr),
    .act(act_c), .tgt(tgt_c));

  assign load_new = req_valid && !bad_kind;

  rtr_hold #(.AW(AW)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(load_new), .act_in(act_c), .addr_in(tgt_c),
    .op_in(op_c), .ready(act_ready), .valid(act_valid), .act_q(act_onehot),
    .addr_q(act_addr), .op_q(op_q));

  assign issue_op    = op_q;
  assign issue_taken = act_valid && act_ready && act_onehot[A_ISSUE];
  assign kind_err    = req_valid && bad_kind;
  assign req_ready   = issue_taken || (kind_err && !act_valid);
  assign excl_err    = req_valid && ($countones({hit_l1i, hit_l1d, hit_l2}) > 1);

  assert_badkind_R10: assert property (@(posedge clk) disable iff (!rst_n)
    kind_err && !act_valid |=> !act_valid);
  assert_consume_R12: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid && act_ready && !act_onehot[A_ISSUE] |-> !req_ready);
endmodule

// File: tb/test_cache_req_router.sv
module test_cache_req_router;
  localparam int AW = 32;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, act_ready = 0;
  logic [2:0] req_kind = 0;
  logic [AW-1:0] req_addr = 0, vi = 0, vd = 0, l2r = 0, l2v = 0;
  logic hi = 0, hd = 0, h2 = 0, fi = 0, fd = 0, fr = 0, fv = 0;
  logic req_ready, act_valid, excl_err, kind_err;
  logic [5:0] act_onehot;
  logic [AW-1:0] act_addr;
  logic [1:0] issue_op;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cache_req_router #(.AW(AW)) i_cache_req_router (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .hit_l1i(hi), .hit_l1d(hd), .hit_l2(h2),
    .free_l1i(fi), .free_l1d(fd), .l2_free_req(fr), .l2_free_vic(fv),
    .l1i_vic_addr(vi), .l1d_vic_addr(vd), .l2_vic_req_addr(l2r), .l2_vic_vic_addr(l2v),
    .act_valid(act_valid), .act_ready(act_ready), .act_onehot(act_onehot),
    .act_addr(act_addr), .issue_op(issue_op), .excl_err(excl_err), .kind_err(kind_err));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected action bit index and address, derived from the requirement text
  function automatic void model(input int kind, output int idx, output logic [AW-1:0] a,
                                output string tag);
    bit f = (kind == 1);
    a = req_addr;
    if ((f && hd) || (!f && hi)) begin
      if (fr) begin idx = f ? 2 : 1; tag = "R2"; end
      else begin idx = 5; a = l2r; tag = "R3"; end
    end else if ((f && hi) || (!f && hd)) begin
      idx = 0; tag = "R4";
    end else if (f ? fi : fd) begin
      if (h2) begin idx = f ? 3 : 4; tag = "R5"; end
      else begin idx = 0; tag = "R6"; end
    end else if (fv) begin
      idx = f ? 1 : 2; a = f ? vi : vd; tag = "R7";
    end else begin
      idx = 5; a = l2v; tag = "R8";
    end
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!act_valid && !req_ready && !excl_err && !kind_err, "R1 reset outputs", act_valid, 0);
    rst_n = 1;
    @(negedge clk);
    for (int k = 0; k < 4; k++)
      for (int hp = 0; hp < 4; hp++)
        for (int r = 0; r < 16; r++) begin
          int c, idx;
          logic [AW-1:0] ea;
          string tag;
          c = k * 64 + hp * 16 + r;
          req_kind = 3'(k);
          req_addr = 32'h1000_0000 + 32'(c * 16);
          vi = 32'hA000_0000 + 32'(c); vd = 32'hB000_0000 + 32'(c);
          l2r = 32'hC000_0000 + 32'(c); l2v = 32'hD000_0000 + 32'(c);
          hi = (hp == 1); hd = (hp == 2); h2 = (hp == 3);
          {fi, fd, fr, fv} = 4'(r);
          model(k, idx, ea, tag);
          req_valid = 1; act_ready = 0;
          #1;
          if (r == 0) chk(!excl_err, "R9 exclusive pattern flag", excl_err, 0);
          @(negedge clk);
          chk(act_valid && act_onehot == 6'(1 << idx), {tag, " action"}, act_onehot, 1 << idx);
          chk(act_addr == ea, {tag, " address"}, act_addr, ea);
          if (idx == 0) chk(issue_op == ((k == 3) ? 2'd2 : 2'(k)), "R4 issue op", issue_op, k);
          @(negedge clk);
          chk(act_valid && act_onehot == 6'(1 << idx) && act_addr == ea && !req_ready,
              "R11 hold while stalled", act_addr, ea);
          act_ready = 1;
          #1;
          chk(req_ready == (idx == 0), "R12 consume only on issue", req_ready, idx == 0);
          @(negedge clk);
          req_valid = 0; act_ready = 0;
          chk(!act_valid, "R11 drop after accept", act_valid, 0);
        end
    // multi-hit patterns
    for (int p = 0; p < 8; p++) begin
      {hi, hd, h2} = 3'(p);
      req_kind = 0; req_valid = 1;
      #1;
      chk(excl_err == ($countones(p) > 1), "R9 multi-hit flag", excl_err, $countones(p) > 1);
      req_valid = 0;
      @(negedge clk);
      @(negedge clk);
      act_ready = 1;
      @(negedge clk);
      act_ready = 0;
    end
    // illegal kinds
    for (int k = 4; k < 8; k++) begin
      req_kind = 3'(k); req_valid = 1; {hi, hd, h2} = 3'b010;
      #1;
      chk(kind_err && req_ready, "R10 illegal kind flagged and consumed", {kind_err, req_ready}, 3);
      @(negedge clk);
      req_valid = 0;
      chk(!act_valid, "R10 no action latched", act_valid, 0);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule